// File: doc/BRIEF.md
# Built-In Logic Block Observer Register

A multi-purpose test register that replaces an ordinary pipeline register on the
boundary of a combinational block. A two-bit mode input picks what it does on each
rising clock edge. It can capture its parallel inputs like any datapath register. It can shift serially from a scan input to a scan output. It can clear itself. Its fourth mode runs a linear-feedback shift register whose stages also XOR in the parallel inputs.

With the parallel inputs held at zero, the fourth mode gives a pseudo-random pattern source. With live inputs, the same mode compacts a stream of response words into a signature. Two instances placed around a combinational block let one drive stimulus while the other compresses the block's answers. The signature is then shifted out through the scan chain. Sequencing the modes and holding the expected signature belong to a controller outside this block.

Top module: `bilbo_reg`

## Requirements
- R1: With mode = 2'b11 (mode[1] first control bit, mode[0] second), the register loads `d` at the next rising edge.
- R2: With mode = 2'b00, the register shifts: stage 0 takes `scan_in` and stage i takes stage i-1.
- R3: With mode = 2'b10, stage 0 takes `d[0]` XOR the feedback bit, and stage i takes `d[i]` XOR stage i-1. The feedback bit is the parity of the state masked by `TAPS`; the default is stage 2 XOR stage 1 for width 3.
- R4: With mode = 2'b01, the register becomes all zeros at the next edge.
- R5: In mode 2'b10 with `d` held at zero and a non-zero seed, the default 3-bit register visits all seven non-zero states and returns to the seed after exactly 7 edges.
- R6: `scan_out` always equals the last stage `q[WIDTH-1]`.
- R7: A synchronous active-high `rst` clears the register at the next edge, whatever the mode.
- R8: In mode 2'b10 with `d` at zero, an all-zero register stays all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Operating mode select |
| d | input | WIDTH | Parallel data / response input |
| scan_in | input | 1 | Serial input to stage 0 in shift mode |
| q | output | WIDTH | Register contents |
| scan_out | output | 1 | Last stage of the register |

## Verification
The properties assume that `mode`, `d` and `scan_in` are known and stable at each rising edge. They also assume the feedback is defined by `TAPS` as a simple parity. The bench changes every input only on the falling edge, so each capture sees settled values. The sweep seeds each of the eight states through a load before it applies each mode, data word and scan bit. It then compares the result against arithmetic computed in the bench. A separate run steps the generator through a full period to confirm the sequence length.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT = 2'b00,
    MODE_CLEAR = 2'b01,
    MODE_SIG   = 2'b10,
    MODE_LOAD  = 2'b11
  } bilbo_mode_e;
endpackage

// File: rtl/bilbo_fb.sv
// Parity of the tapped stages: feedback bit for the LFSR/MISR mode.
module bilbo_fb #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] TAPS = 3'b110
) (
  input  logic [WIDTH-1:0] state,
  output logic             fb
);
  always_comb fb = ^(state & TAPS);
endmodule

// File: rtl/bilbo_head_mux.sv
// Serial input of stage 0: scan data in shift mode, feedback otherwise.
module bilbo_head_mux
  import bilbo_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       scan_in,
  input  logic       fb,
  output logic       head
);
  always_comb head = (bilbo_mode_e'(mode) == MODE_SHIFT) ? scan_in : fb;
endmodule

// File: rtl/bilbo_next.sv
// Per-stage next-state selection.
module bilbo_next
  import bilbo_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] state,
  input  logic [WIDTH-1:0] d,
  input  logic             head,
  output logic [WIDTH-1:0] nxt
);
  logic [WIDTH-1:0] chain;

  always_comb chain = {state[WIDTH-2:0], head};

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    always_comb begin
      unique case (bilbo_mode_e'(mode))
        MODE_LOAD:  nxt[i] = d[i];
        MODE_SHIFT: nxt[i] = chain[i];
        MODE_SIG:   nxt[i] = chain[i] ^ d[i];
        default:    nxt[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] TAPS = 3'b110
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] d,
  input  logic             scan_in,
  output logic [WIDTH-1:0] q,
  output logic             scan_out
);
  logic             fb;
  logic             head;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] state_r;

  bilbo_fb #(.WIDTH(WIDTH), .TAPS(TAPS)) u_fb (
    .state (state_r),
    .fb    (fb)
  );

  bilbo_head_mux u_head (
    .mode    (mode),
    .scan_in (scan_in),
    .fb      (fb),
    .head    (head)
  );

  bilbo_next #(.WIDTH(WIDTH)) u_next (
    .mode  (mode),
    .state (state_r),
    .d     (d),
    .head  (head),
    .nxt   (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) state_r <= '0;
    else     state_r <= nxt;
  end

  assign q        = state_r;
  assign scan_out = state_r[WIDTH-1];
endmodule

// File: rtl/bilbo_reg_chk.sv
module bilbo_reg_chk #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] TAPS = 3'b110
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] d,
  input logic             scan_in,
  input logic [WIDTH-1:0] q,
  input logic             scan_out
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> q == '0); // R7
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b11 |=> q == $past(d)); // R1
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b00 |=> q == {$past(q[WIDTH-2:0]), $past(scan_in)}); // R2
  AST_CLEAR_MODE: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b01 |=> q == '0); // R4
  AST_SIG_STEP: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b10 |=> q == ({$past(q[WIDTH-2:0]), ^($past(q) & TAPS)} ^ $past(d))); // R3
  AST_ZERO_LOCK: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && d == '0 && q == '0) |=> q == '0); // R8
  AST_TAIL_OUT: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b00 |=> scan_out == $past(q[WIDTH-2])); // R6
endmodule

bind bilbo_reg bilbo_reg_chk #(.WIDTH(WIDTH), .TAPS(TAPS)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .d(d), .scan_in(scan_in),
  .q(q), .scan_out(scan_out)
);

// File: tb/bilbo_reg_tb.sv
module bilbo_reg_tb;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b11;
  logic [2:0] d = '0;
  logic       scan_in = 1'b0;
  logic [2:0] q;
  logic       scan_out;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  bilbo_reg u_dut (
    .clk(clk), .rst(rst), .mode(mode), .d(d), .scan_in(scan_in),
    .q(q), .scan_out(scan_out)
  );

  function automatic logic [2:0] ref_next(logic [2:0] cur, logic [1:0] m,
                                          logic [2:0] dd, logic s);
    case (m)
      2'b11:   return dd;
      2'b00:   return {cur[1:0], s};
      2'b01:   return 3'b000;
      default: return {cur[1] ^ dd[2], cur[0] ^ dd[1], (cur[2] ^ cur[1]) ^ dd[0]};
    endcase
  endfunction

  task automatic check(string tag, logic [2:0] exp);
    n_vec++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s q=%b expected=%b", tag, q, exp);
    end
    n_vec++;
    if (scan_out !== exp[2]) begin
      n_bad++;
      $display("FAIL R6 scan_out=%b expected=%b", scan_out, exp[2]);
    end
  endtask

  task automatic step(logic r, logic [1:0] m, logic [2:0] dd, logic s);
    @(negedge clk);
    rst = r; mode = m; d = dd; scan_in = s;
    @(posedge clk);
    #(PERIOD/4);
  endtask

  initial begin
    logic [2:0] exp;
    logic [2:0] seen;
    step(1'b1, 2'b11, 3'b101, 1'b0);
    step(1'b1, 2'b11, 3'b101, 1'b0);
    check("R7 reset", 3'b000);
    step(1'b0, 2'b11, 3'b110, 1'b0);
    step(1'b1, 2'b11, 3'b011, 1'b1);
    check("R7 reset over load", 3'b000);

    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 8; s++)
        for (int v = 0; v < 8; v++)
          for (int b = 0; b < 2; b++) begin
            step(1'b0, 2'b11, 3'(s), 1'b0);
            check("R1 seed load", 3'(s));
            step(1'b0, 2'(m), 3'(v), 1'(b));
            exp = ref_next(3'(s), 2'(m), 3'(v), 1'(b));
            case (m)
              0: check("R2 shift", exp);
              1: check("R4 clear", exp);
              2: check("R3 signature", exp);
              default: check("R1 load", exp);
            endcase
          end

    // R5: full period from seed 001 with d held at zero
    step(1'b0, 2'b11, 3'b001, 1'b0);
    seen = 3'b001;
    exp = 3'b001;
    for (int k = 1; k <= 7; k++) begin
      step(1'b0, 2'b10, 3'b000, 1'b0);
      exp = ref_next(exp, 2'b10, 3'b000, 1'b0);
      check("R5 generator step", exp);
      n_vec++;
      if (k < 7 && (q == 3'b001 || q == 3'b000)) begin
        n_bad++;
        $display("FAIL R5 early repeat q=%b expected=not 001/000", q);
      end
    end
    check("R5 period 7", 3'b001);

    // R8: zero lock
    step(1'b0, 2'b01, 3'b000, 1'b0);
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 2'b10, 3'b000, 1'b0);
      check("R8 zero lock", 3'b000);
    end

    // R2/R6: shift a pattern through the chain
    step(1'b0, 2'b01, 3'b000, 1'b0);
    exp = 3'b000;
    for (int k = 0; k < 6; k++) begin
      step(1'b0, 2'b00, 3'b111, 1'(k % 2));
      exp = {exp[1:0], 1'(k % 2)};
      check("R2 serial stream", exp);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired q=%b expected=done", q);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule